// File: doc/BRIEF.md
# Triggered Pixel-Array Readout Controller

This controller holds the hit record of every pixel in a 16 by 16 grid of per-pixel time converters and sends the whole grid out as one serial frame when a trigger pulse arrives. A pixel's record is an 8-bit time code. The upper nibble is the coarse count and the lower nibble is the fine count. The controller keeps only the first hit a pixel sees. A pixel can be masked so that a channel known to be faulty never contributes data. Each pixel also has a test-pulse enable bit that is brought out to the front-end.

Two retention policies are available. With the auto-clear policy on, a stored hit is dropped if no trigger follows within a latency window of 14 coarse clock cycles (350 ns at 40 MHz). With the policy off, a stored hit is held until it is read out. A frame always has the same length: 256 slots of 9 bits, in pixel order 0 to 255. Each slot is a presence bit followed by the time code, MSB first. Each pixel is cleared once its slot has been sent. The controller pulses a per-pixel clear strobe whenever it drops a pixel's record, either because the window expired or because the slot was sent.

Top module: `pxro_readout`

## Requirements
- R1: After reset, `ser_o`, `frame_start_o`, `frame_end_o`, every `clr_o` bit and every `tp_en_o` bit are 0.
- R2: An unmasked pixel that holds no record and sees `hit_i` high at a clock edge while no frame is active stores its 8-bit time code (coarse in bits 7:4, fine in bits 3:0). Further hits to that pixel are ignored until the pixel is cleared.
- R3: A masked pixel never stores a hit, and its slot in the frame is all zeros.
- R4: A trigger sampled while idle starts a frame in the next cycle. The frame is one bit per cycle, pixel 0 first. Each 9-bit slot is a presence bit (1 = hit stored) followed by the time code MSB first, and an empty pixel's slot is all zeros. `frame_start_o` is high during the first bit only, `frame_end_o` is high during the 2304th bit only, and the controller is idle after that.
- R5: A trigger that arrives while a frame is being sent is ignored and starts no second frame.
- R6: During the last bit of a pixel's slot, `clr_o` for that pixel is high and the pixel's record is cleared, so a frame that follows at once with no new hits is all zeros.
- R7: With `clear_on_i` = 1, a record stored at edge E is dropped at edge E+14 unless a trigger is sampled on or before that edge. `clr_o` for that pixel is high in the cycle just before E+14. Timers do not run while a frame is active.
- R8: With `clear_on_i` = 0, a stored record is kept however long the trigger is delayed.
- R9: A cycle with `cfg_we_i` = 1 loads `cfg_mask_i` and `cfg_tp_i` into the pixel selected by `cfg_addr_i`. That pixel's `tp_en_o` bit then follows its stored test-pulse bit, and no other pixel changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Coarse clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| read_i | input | 1 | Read/trigger request |
| clear_on_i | input | 1 | 1 = drop records after the latency window |
| hit_i | input | 256 | Per-pixel hit flags |
| hit_data_i | input | 2048 | Per-pixel 8-bit time codes, pixel p at bits 8p+7:8p |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Pixel selected for a configuration write |
| cfg_mask_i | input | 1 | Mask bit to write |
| cfg_tp_i | input | 1 | Test-pulse enable bit to write |
| ser_o | output | 1 | Serial frame data |
| frame_start_o | output | 1 | High during the first frame bit |
| frame_end_o | output | 1 | High during the last frame bit |
| clr_o | output | 256 | Per-pixel clear strobes |
| tp_en_o | output | 256 | Per-pixel test-pulse enables |

## Verification
The assertions assume that `clear_on_i` is held steady around the edges where a record is ageing, so that the retention rule applied at an edge is the one the property samples. They also assume that configuration writes are the only way the mask changes. The stimulus changes the mode only while every pixel is empty, and it drives all inputs on the falling edge. The bench triggers frames with known hit sets and also triggers in the middle of a frame. It places two hits one cycle apart so that a single trigger falls exactly on one pixel's expiry edge and one edge after the other's.

// File: rtl/pxro_pkg.sv
package pxro_pkg;
  localparam int unsigned GRID_ROWS  = 16;
  localparam int unsigned GRID_COLS  = 16;
  localparam int unsigned CODE_W     = 8;
  localparam int unsigned WINDOW_CYC = 14;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_SHIFT
  } seq_state_e;
endpackage

// File: rtl/pxro_cell.sv
module pxro_cell #(
  parameter int unsigned WORD_W  = pxro_pkg::CODE_W,
  parameter int unsigned TMO_CYC = pxro_pkg::WINDOW_CYC,
  parameter int unsigned SLOT_W  = WORD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              clear_on_i,
  input  logic              freeze_i,
  input  logic              rd_clr_i,
  input  logic              cfg_we_i,
  input  logic              cfg_mask_i,
  input  logic              cfg_tp_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              tp_en_o,
  output logic              clr_o
);
  localparam int unsigned AGE_W = $clog2(TMO_CYC);

  logic              valid_q, mask_q, tp_q;
  logic [WORD_W-1:0] data_q;
  logic [AGE_W-1:0]  age_q;
  logic              ageing, tmo_fire, capture;

  assign ageing   = valid_q && clear_on_i && !freeze_i;
  assign tmo_fire = ageing && (age_q == AGE_W'(TMO_CYC - 1));
  assign capture  = hit_i && !valid_q && !mask_q && !freeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mask_q  <= 1'b0;
      tp_q    <= 1'b0;
      data_q  <= '0;
      age_q   <= '0;
    end else begin
      if (cfg_we_i) begin
        mask_q <= cfg_mask_i;
        tp_q   <= cfg_tp_i;
      end
      if (rd_clr_i || tmo_fire) begin
        valid_q <= 1'b0;
        age_q   <= '0;
      end else if (capture) begin
        valid_q <= 1'b1;
        data_q  <= data_i;
        age_q   <= '0;
      end else if (ageing) begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  assign slot_o  = (valid_q && !mask_q) ? {1'b1, data_q} : '0;
  assign tp_en_o = tp_q;
  assign clr_o   = rd_clr_i || tmo_fire;

  a_r3_masked_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q && !valid_q) |=> !valid_q);
  a_r8_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !clear_on_i && !rd_clr_i) |=> valid_q);
  a_r7_age_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (age_q < AGE_W'(TMO_CYC)));
  a_r2_first_hit_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !clr_o) |=> $stable(data_q));
endmodule

// File: rtl/pxro_seq.sv
module pxro_seq #(
  parameter int unsigned NPIX   = 256,
  parameter int unsigned BITS   = 9,
  parameter int unsigned IDX_W  = $clog2(NPIX),
  parameter int unsigned BIT_W  = $clog2(BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             read_i,
  output logic             busy_o,
  output logic             freeze_o,
  output logic [IDX_W-1:0] sel_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             last_bit_o,
  output logic             frame_start_o,
  output logic             frame_end_o
);
  import pxro_pkg::*;

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [BIT_W-1:0] bit_q;
  logic             busy, start, last_bit, last_pix;

  assign busy     = (state_q == SEQ_SHIFT);
  assign start    = read_i && !busy;
  assign last_bit = busy && (bit_q == BIT_W'(BITS - 1));
  assign last_pix = (idx_q == IDX_W'(NPIX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      bit_q   <= '0;
    end else if (start) begin
      state_q <= SEQ_SHIFT;
      idx_q   <= '0;
      bit_q   <= '0;
    end else if (busy) begin
      if (last_bit) begin
        bit_q <= '0;
        if (last_pix) state_q <= SEQ_IDLE;
        else          idx_q   <= idx_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign busy_o        = busy;
  assign freeze_o      = busy || start;
  assign sel_o         = idx_q;
  assign bit_o         = bit_q;
  assign last_bit_o    = last_bit;
  assign frame_start_o = busy && (idx_q == '0) && (bit_q == '0);
  assign frame_end_o   = last_bit && last_pix;

  a_r4_busy_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !frame_end_o) |=> busy_o);
  a_r4_end_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !busy_o);
  a_r5_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && read_i && !frame_end_o) |=> !frame_start_o);
  a_r4_markers_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_start_o && frame_end_o));
endmodule

// File: rtl/pxro_readout.sv
module pxro_readout #(
  parameter int unsigned ROWS    = pxro_pkg::GRID_ROWS,
  parameter int unsigned COLS    = pxro_pkg::GRID_COLS,
  parameter int unsigned WORD_W  = pxro_pkg::CODE_W,
  parameter int unsigned TMO_CYC = pxro_pkg::WINDOW_CYC,
  parameter int unsigned NPIX    = ROWS * COLS,
  parameter int unsigned IDX_W   = $clog2(NPIX)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     read_i,
  input  logic                     clear_on_i,
  input  logic [NPIX-1:0]          hit_i,
  input  logic [NPIX*WORD_W-1:0]   hit_data_i,
  input  logic                     cfg_we_i,
  input  logic [IDX_W-1:0]         cfg_addr_i,
  input  logic                     cfg_mask_i,
  input  logic                     cfg_tp_i,
  output logic                     ser_o,
  output logic                     frame_start_o,
  output logic                     frame_end_o,
  output logic [NPIX-1:0]          clr_o,
  output logic [NPIX-1:0]          tp_en_o
);
  localparam int unsigned BITS  = WORD_W + 1;
  localparam int unsigned BIT_W = $clog2(BITS);

  logic             busy, freeze, last_bit;
  logic [IDX_W-1:0] sel;
  logic [BIT_W-1:0] bit_idx;
  logic [NPIX-1:0]  rd_clr;
  logic [BITS-1:0]  slot_arr [NPIX];
  logic [BITS-1:0]  cur_slot;
  logic             cur_bit;

  pxro_seq #(.NPIX(NPIX), .BITS(BITS), .IDX_W(IDX_W), .BIT_W(BIT_W)) u_seq (
    .clk_i, .rst_ni, .read_i,
    .busy_o(busy), .freeze_o(freeze), .sel_o(sel), .bit_o(bit_idx),
    .last_bit_o(last_bit), .frame_start_o, .frame_end_o
  );

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    assign rd_clr[p] = last_bit && (sel == IDX_W'(p));
    pxro_cell #(.WORD_W(WORD_W), .TMO_CYC(TMO_CYC), .SLOT_W(BITS)) u_cell (
      .clk_i, .rst_ni,
      .hit_i      (hit_i[p]),
      .data_i     (hit_data_i[p*WORD_W +: WORD_W]),
      .clear_on_i,
      .freeze_i   (freeze),
      .rd_clr_i   (rd_clr[p]),
      .cfg_we_i   (cfg_we_i && (cfg_addr_i == IDX_W'(p))),
      .cfg_mask_i,
      .cfg_tp_i,
      .slot_o     (slot_arr[p]),
      .tp_en_o    (tp_en_o[p]),
      .clr_o      (clr_o[p])
    );
  end

  assign cur_slot = slot_arr[sel];

  always_comb begin
    cur_bit = 1'b0;
    for (int b = 0; b < BITS; b++)
      if (bit_idx == BIT_W'(b)) cur_bit = cur_slot[BITS-1-b];
  end

  assign ser_o = busy && cur_bit;

  a_r6_one_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_clr));
  a_r6_clear_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr != '0) |-> busy);
endmodule

// File: tb/pxro_readout_test.sv
module pxro_readout_test;
  localparam int NP = 256;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic read_i = 1'b0, clear_on_i = 1'b0;
  logic [NP-1:0] hit_i = '0;
  logic [NP*WW-1:0] hit_data_i = '0;
  logic cfg_we_i = 1'b0, cfg_mask_i = 1'b0, cfg_tp_i = 1'b0;
  logic [7:0] cfg_addr_i = '0;
  logic ser_o, frame_start_o, frame_end_o;
  logic [NP-1:0] clr_o, tp_en_o;

  pxro_readout uut (
    .clk_i(clk), .rst_ni, .read_i, .clear_on_i, .hit_i, .hit_data_i,
    .cfg_we_i, .cfg_addr_i, .cfg_mask_i, .cfg_tp_i,
    .ser_o, .frame_start_o, .frame_end_o, .clr_o, .tp_en_o
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, frames_seen = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  bit e_val [NP];
  bit e_msk [NP];
  logic [7:0] e_dat [NP];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: rebuild slots from the serial stream and compare with the scoreboard
  bit in_frame = 0;
  int wi = 0, bi = 0;
  logic [8:0] acc;
  logic [8:0] want;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (frame_start_o) begin
        frames_seen++;
        in_frame = 1; wi = 0; bi = 0;
      end
      if (in_frame) begin
        acc = {acc[7:0], ser_o};
        bi++;
        if (bi == 9) begin
          if (exp_q.size() == 0) chk("R4 slot without expectation", 32'(wi), 32'hFFFF);
          else begin
            want = exp_q.pop_front();
            chk($sformatf("R4 slot %0d", wi), 32'(acc), 32'(want));
          end
          chk($sformatf("R6 clear strobe pixel %0d", wi), 32'(clr_o[wi]), 32'd1);
          chk("R4 frame_end placement", 32'(frame_end_o), (wi == NP-1) ? 32'd1 : 32'd0);
          if (wi == NP-1) in_frame = 0;
          wi++; bi = 0;
        end
      end
    end
  end

  task automatic hit(input int p, input logic [7:0] d);
    @(negedge clk);
    hit_i[p] = 1'b1;
    hit_data_i[p*WW +: WW] = d;
    if (!e_msk[p] && !e_val[p]) begin e_val[p] = 1; e_dat[p] = d; end
    @(negedge clk);
    hit_i[p] = 1'b0;
  endtask

  task automatic push_frame();
    for (int p = 0; p < NP; p++) begin
      exp_q.push_back(e_val[p] ? {1'b1, e_dat[p]} : 9'd0);
      e_val[p] = 0;
    end
  endtask

  task automatic pulse_read();
    @(negedge clk); read_i = 1'b1;
    @(negedge clk); read_i = 1'b0;
  endtask

  task automatic cfg_write(input int p, input bit m, input bit t);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = 8'(p); cfg_mask_i = m; cfg_tp_i = t;
    @(negedge clk);
    cfg_we_i = 1'b0;
    e_msk[p] = m;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    for (int p = 0; p < NP; p++) begin e_val[p] = 0; e_msk[p] = 0; e_dat[p] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ser_o", 32'(ser_o), 0);
    chk("R1 frame markers", 32'({frame_start_o, frame_end_o}), 0);
    chk("R1 clr_o count", 32'($countones(clr_o)), 0);
    chk("R1 tp_en_o count", 32'($countones(tp_en_o)), 0);

    // R9 configuration: mask pixel 5, test pulse on pixel 7
    cfg_write(5, 1, 0);
    cfg_write(7, 0, 1);
    @(negedge clk);
    chk("R9 tp_en pixel 7", 32'(tp_en_o[7]), 1);
    chk("R9 tp_en only one", 32'($countones(tp_en_o)), 1);

    // Frame 1, clear-off: R2 first hit kept, R3 mask, R8 retention, R5 mid-frame trigger
    clear_on_i = 1'b0;
    hit(0, 8'h12);
    hit(5, 8'hFF);
    hit(17, 8'h3A);
    hit(17, 8'hC5);
    hit(128, 8'h80);
    hit(255, 8'hE7);
    repeat (40) @(negedge clk);
    chk("R8 no drop strobe after long wait", 32'($countones(clr_o)), 0);
    f0 = frames_seen;
    push_frame();
    pulse_read();
    repeat (300) @(negedge clk);
    pulse_read();                       // R5: ignored during active frame
    repeat (2100) @(negedge clk);
    chk("R5 single frame despite second trigger", 32'(frames_seen - f0), 1);
    chk("R4 scoreboard drained", 32'(exp_q.size()), 0);

    // Frame 2: no new hits, pixels were cleared by readout (R6)
    push_frame();
    pulse_read();
    repeat (2310) @(negedge clk);
    chk("R6 empty follow-up frame seen", 32'(frames_seen - f0), 2);
    chk("R6 scoreboard drained", 32'(exp_q.size()), 0);

    // Frame 3, clear-on boundary: pixel 40 stored at E, pixel 41 at E+1, trigger at E+15 (R7)
    clear_on_i = 1'b1;
    @(negedge clk);
    hit_i[40] = 1'b1; hit_data_i[40*WW +: WW] = 8'h5B;     // N0
    @(negedge clk);
    hit_i[40] = 1'b0;
    hit_i[41] = 1'b1; hit_data_i[41*WW +: WW] = 8'hA6;     // N1
    @(negedge clk);
    hit_i[41] = 1'b0;                                       // N2
    repeat (11) @(negedge clk);                             // N13
    chk("R7 no early drop pixel 40", 32'(clr_o[40]), 0);
    @(negedge clk);                                         // N14
    chk("R7 drop strobe pixel 40", 32'(clr_o[40]), 1);
    chk("R7 pixel 41 still ageing", 32'(clr_o[41]), 0);
    e_val[40] = 0;
    e_val[41] = 1; e_dat[41] = 8'hA6;
    push_frame();
    @(negedge clk); read_i = 1'b1;                          // N15 -> sampled at E+15
    @(negedge clk); read_i = 1'b0;
    repeat (2310) @(negedge clk);
    chk("R7 boundary frame seen", 32'(frames_seen - f0), 3);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 0);
    clear_on_i = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule